// File: doc/BRIEF.md
# Byte-Wide SPI Master with Access-Ordered Flags

This block is a synchronous SPI master that exchanges one byte at a time with an external device. A CPU reaches it through three small registers. The control register sets the idle level of the serial clock, the clock-to-data phase scheme, the bit-rate divider and an interrupt enable. The status register reports transfer completion and write collisions. A write to the data register starts an exchange, and a read of the data register returns the byte that was shifted in.

The flags clear only in a fixed order. Software first reads the status register while a flag is set, which arms the clear. The next data-register access, either a read or a write, then clears the flags. While the completion flag is set and the clear has not been armed, data-register writes are discarded. This means a new byte cannot overwrite a result that has not been acknowledged. A data write that arrives while a byte is still shifting is dropped and sets the collision flag.

Register select: 0 is control, 1 is status, 2 is data. Control bits: 7 is interrupt enable, 3 is clock idle level, 2 is phase scheme, 1:0 is rate. Status bits: 7 is complete, 6 is collision, 4 is mode fault. All other bits read 0.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control and status registers read 0x00, sck is low and irq is low.
- R2: While no exchange is running, sck rests at the level of control bit 3. Each exchange produces exactly 8 clock pulses and returns sck to that level.
- R3: Rate field values 0, 1, 2 and 3 give an sck period of 2, 4, 16 and 32 system clocks. The complete flag rises 8×period system clocks after the data write is accepted.
- R4: With control bit 2 at 0, the exchange is full duplex and MSB first. Each outgoing bit is valid on mosi before the leading sck edge, and miso is captured on that leading edge.
- R5: With control bit 2 at 1, mosi changes on each leading sck edge and miso is captured on the trailing edge. The exchange is still full duplex and MSB first.
- R6: Status bit 7 is set when an exchange finishes. irq equals status bit 7 ANDed with control bit 7.
- R7: A status read that sees bit 7 or bit 6 set, followed by a data-register read or write, clears both flags. A data access without that prior status read leaves the flags set.
- R8: A data write while status bit 7 is set and the clear is not armed is ignored: no exchange starts and the data register keeps its value.
- R9: A data write while an exchange is running is ignored, does not disturb that exchange, and sets status bit 6. The bit clears through the R7 sequence.
- R10: Status bit 4 (mode fault) and the unused status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The exchange is driven through a table that covers every pairing of idle level and phase scheme, each at a different rate. A modelled slave returns its own byte and records what it receives. The byte patterns include all-ones, all-zeros, a single set bit at each end and alternating bits. These patterns expose a reversed bit order, a dropped or duplicated first or last bit, and capture on the wrong sck edge. The measured time from the write to the complete flag separates the four divide ratios. Directed cases then exercise writes that arrive too early in the clear sequence, writes during a running exchange, and the interrupt mask.

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);
  localparam int NEDGE = 2 * DW;
  localparam int EW = $clog2(NEDGE);

  logic [7:0]    ctrl_q;
  logic [DW-1:0] shft_q;
  logic [EW-1:0] edge_q;
  logic [3:0]    div_q, half_m1;
  logic smp_q, mosi_q, phase_q, busy_q, done_q, wcol_q, armed_q;

  wire ie   = ctrl_q[7];
  wire cpol = ctrl_q[3];
  wire cpha = ctrl_q[2];

  always_comb
    case (ctrl_q[1:0])
      2'd0:    half_m1 = 4'd0;
      2'd1:    half_m1 = 4'd1;
      2'd2:    half_m1 = 4'd7;
      default: half_m1 = 4'd15;
    endcase

  wire sel_ctl = reg_sel == 2'd0;
  wire sel_sts = reg_sel == 2'd1;
  wire sel_dat = reg_sel == 2'd2;
  wire sts_rd  = rd_en & sel_sts;
  wire dat_wr  = wr_en & sel_dat;
  wire dat_acc = (rd_en | wr_en) & sel_dat;
  wire ok_wr   = dat_wr & ~busy_q & ~(done_q & ~armed_q);
  wire tick    = busy_q & (div_q == half_m1);
  wire lead    = tick & ~edge_q[0];
  wire last    = tick & (edge_q == EW'(NEDGE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      shft_q  <= '0;
      edge_q  <= '0;
      div_q   <= '0;
      smp_q   <= 1'b0;
      mosi_q  <= 1'b0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_en & sel_ctl) ctrl_q <= wdata;

      if (ok_wr) begin
        shft_q  <= wdata[DW-1:0];
        busy_q  <= 1'b1;
        edge_q  <= '0;
        div_q   <= '0;
        phase_q <= 1'b0;
      end else if (busy_q) begin
        if (tick) begin
          div_q   <= '0;
          edge_q  <= edge_q + 1'b1;
          phase_q <= ~phase_q;
          if (lead) begin
            if (cpha) mosi_q <= shft_q[DW-1];
            else      smp_q  <= miso;
          end else begin
            shft_q <= {shft_q[DW-2:0], cpha ? miso : smp_q};
          end
          if (last) busy_q <= 1'b0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end

      if (dat_acc & armed_q) begin
        done_q  <= 1'b0;
        wcol_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (sts_rd & (done_q | wcol_q)) begin
        armed_q <= 1'b1;
      end
      if (last) done_q <= 1'b1;
      if (dat_wr & busy_q) wcol_q <= 1'b1;
    end
  end

  assign sck  = cpol ^ phase_q;
  assign mosi = cpha ? mosi_q : shft_q[DW-1];
  assign irq  = ie & done_q;

  always_comb
    case (1'b1)
      sel_ctl: rdata = ctrl_q;
      sel_sts: rdata = {done_q, wcol_q, 1'b0, 1'b0, 4'b0};
      sel_dat: rdata = 8'(shft_q);
      default: rdata = 8'h00;
    endcase

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck == cpol);
  a_r6_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  a_r7_clear_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && armed_q && !busy_q) |=> !done_q);
  a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && done_q && !armed_q && !busy_q) |=> !busy_q);
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && busy_q) |=> wcol_q);
endmodule

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic sck, mosi, miso, irq;

  spi_byte_master dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
  int s_idx = 0;
  logic s_on = 1'b0, tb_cpol = 1'b0, tb_cpha = 1'b0;
  assign miso = (s_idx < 8) ? s_tx[7 - s_idx] : 1'b0;

  always @(sck) begin
    if (s_on) begin
      if (sck !== tb_cpol) begin
        if (!tb_cpha) s_rx = {s_rx[6:0], mosi};
      end else begin
        if (tb_cpha) s_rx = {s_rx[6:0], mosi};
        s_idx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sel, input bit wr, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    reg_sel = sel; wdata = d; wr_en = wr; rd_en = ~wr;
    q = rdata;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; reg_sel = 2'd1;
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [7:0] stx);
    logic [7:0] q;
    s_on = 1'b0;
    acc(2'd0, 1'b1, ctl, q);
    tb_cpol = ctl[3]; tb_cpha = ctl[2];
    s_tx = stx; s_idx = 0; s_rx = 8'h00; s_on = 1'b1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    reg_sel = 2'd1;
    while (n < 2000) begin
      @(posedge clk); #1; n++;
      if (rdata[7]) break;
    end
  endtask

  // {cpol, cpha, rate, tx, slave tx}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 2'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 2'd2, 8'hFF, 8'h00},
    {1'b1, 1'b1, 2'd3, 8'h00, 8'hFF},
    {1'b0, 1'b0, 2'd3, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 2'd0, 8'h01, 8'h80},
    {1'b0, 1'b1, 2'd2, 8'h96, 8'h69},
    {1'b1, 1'b0, 2'd1, 8'h7F, 8'hFE}
  };

  initial begin
    #4_000_000;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int n, div, edges;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 2'd0; #1 chk(rdata == 8'h00, "R1 control", rdata, 0);
    reg_sel = 2'd1; #1 chk(rdata == 8'h00, "R1 status", rdata, 0);
    chk(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {sck, irq}, 0);

    foreach (VEC[i]) begin
      logic [7:0] ctl, tx, stx;
      ctl = {1'b1, 3'b000, VEC[i][19:16]};
      tx = VEC[i][15:8]; stx = VEC[i][7:0];
      div = (VEC[i][17:16] == 2'd0) ? 2 : (VEC[i][17:16] == 2'd1) ? 4 :
            (VEC[i][17:16] == 2'd2) ? 16 : 32;
      setup(ctl, stx);
      @(negedge clk);
      chk(sck == ctl[3], "R2 idle level", sck, ctl[3]);
      acc(2'd2, 1'b1, tx, q);
      wait_done(n);
      chk(n == 8 * div, "R3 duration", n, 8 * div);
      reg_sel = 2'd2; #1;
      chk(rdata == stx, ctl[2] ? "R5 rx byte" : "R4 rx byte", rdata, stx);
      chk(s_rx == tx, ctl[2] ? "R5 tx byte" : "R4 tx byte", s_rx, tx);
      chk(s_idx == 8 && sck == ctl[3], "R2 pulses", s_idx, 8);
      reg_sel = 2'd1; #1;
      chk(rdata == 8'h80, "R10 status value", rdata, 8'h80);
      chk(irq == 1'b1, "R6 irq", irq, 1);
      acc(2'd1, 1'b0, 8'h00, q);
      acc(2'd2, 1'b0, 8'h00, q);
      #1 chk(rdata == 8'h00 && irq == 1'b0, "R7 cleared", {rdata, irq}, 0);
    end

    // R8 and R7: write without the status read is ignored, flag stays
    setup(8'h80, 8'h42);
    acc(2'd2, 1'b1, 8'hC0, q);
    wait_done(n);
    s_on = 1'b0;
    edges = 0;
    acc(2'd2, 1'b0, 8'h00, q);
    acc(2'd2, 1'b1, 8'h55, q);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (sck !== 1'b0) edges++;
    end
    chk(edges == 0, "R8 no sck activity", edges, 0);
    reg_sel = 2'd2; #1 chk(rdata == 8'h42, "R8 data kept", rdata, 8'h42);
    reg_sel = 2'd1; #1 chk(rdata == 8'h80 && irq, "R7 flag kept", rdata, 8'h80);
    acc(2'd1, 1'b0, 8'h00, q);
    acc(2'd2, 1'b0, 8'h00, q);
    #1 chk(rdata == 8'h00, "R7 cleared after sequence", rdata, 0);

    // R9 collision during a slow exchange
    setup(8'h83, 8'h9D);
    acc(2'd2, 1'b1, 8'h3E, q);
    repeat (20) @(posedge clk);
    acc(2'd2, 1'b1, 8'hFF, q);
    reg_sel = 2'd1; #1 chk(rdata[6] == 1'b1, "R9 collision flag", rdata, 8'h40);
    wait_done(n);
    reg_sel = 2'd2; #1 chk(rdata == 8'h9D, "R9 exchange intact rx", rdata, 8'h9D);
    chk(s_rx == 8'h3E, "R9 exchange intact tx", s_rx, 8'h3E);
    reg_sel = 2'd1; #1 chk(rdata == 8'hC0, "R9 both flags", rdata, 8'hC0);
    acc(2'd1, 1'b0, 8'h00, q);
    acc(2'd2, 1'b0, 8'h00, q);
    #1 chk(rdata == 8'h00, "R9 collision cleared", rdata, 0);

    // R6 masked interrupt
    setup(8'h04, 8'h11);
    acc(2'd2, 1'b1, 8'h22, q);
    wait_done(n);
    chk(irq == 1'b0, "R6 masked irq", irq, 0);
    chk(rdata == 8'h80, "R6 flag without enable", rdata, 8'h80);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule